// File: doc/BRIEF.md
# Multiplexed A/D scan sequencer

This block drives the select lines of a 32-way analog multiplexer and steps them through a window of adjacent channels. Each accepted trigger starts one conversion. A trigger can come from a register write, from a pacer tick, or from an external pulse, and control bits choose which of these are live. The converter is modelled inside the block. It takes a conversion a fixed number of cycles after the trigger and then presents the result tagged with the channel it was taken from.

A small table holds a gain code for each channel. To load one entry, first narrow the window to that single channel, then write the gain register. While a channel is selected, the block drives its gain code out to the front end. Software programs the block through a write-only register port with four addresses: 0 is the trigger strobe, 1 is gain, 2 is the window, and 3 is control.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the window is channel 0 only (mux_chan = 0), every gain entry is 0, all trigger sources are disabled, and conv_busy, sample_valid and overrun are 0.
- R2: A write to address 2 sets the window's first channel from wr_data[7:0] and its last channel from wr_data[15:8], using the low 5 bits of each. It also moves mux_chan to the first channel.
- R3: When a conversion completes, mux_chan moves to the next channel. After the last channel it returns to the first. When the last channel is below the first, the scan runs through 31 and wraps to 0.
- R4: A write to address 1 stores wr_data into the gain entry of the selected channel only when the first and last channels are equal and the code is 0x00–0x07 or 0x10–0x13. Any other gain write leaves the table unchanged.
- R5: gain_code always shows the table entry for the channel on mux_chan, including throughout a conversion.
- R6: sample_valid pulses for one cycle, LATENCY clock edges after the edge that accepted the trigger. sample_data[15:12] holds the low 4 bits of the converted channel, and sample_data[11:0] holds adc_in as sampled at that edge.
- R7: Control (address 3) bit 0 enables the strobe trigger, bit 1 the pacer, bit 2 the external trigger, and bit 3 gating of the external trigger. A source whose bit is clear starts nothing.
- R8: With bit 0 set, each write to address 0 starts exactly one conversion.
- R9: An external trigger is a rising edge of ext_trig. When gating is on, it counts only while ext_gate is high.
- R10: A trigger that arrives while conv_busy is high starts nothing and sets overrun, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 trigger, 1 gain, 2 window, 3 control) |
| wr_data | input | 16 | Register write data |
| pacer_tick | input | 1 | Single-cycle pacer pulse |
| ext_trig | input | 1 | External trigger level; rising edge counts |
| ext_gate | input | 1 | External gate |
| adc_in | input | 12 | Converter result, sampled at completion |
| mux_chan | output | 5 | Multiplexer channel select |
| gain_code | output | 5 | Gain code for the selected channel |
| conv_busy | output | 1 | Conversion in progress |
| sample_valid | output | 1 | One-cycle result strobe |
| sample_data | output | 16 | Channel tag and conversion result |
| overrun | output | 1 | Sticky lost-trigger flag |

## Verification
The sharpest case is a new trigger landing in the very cycle a conversion completes. At that edge the block must emit the finished sample, advance the channel, and still refuse the trigger. The bench provokes this by issuing a second strobe write timed to arrive exactly LATENCY cycles after the first. It then judges the outcome on three counts: the scoreboard receives exactly one sample, with the expected tag; overrun reads 1; and no further sample follows.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH     = 32,
  parameter int LATENCY = 4,
  parameter int DW      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  input  logic              ext_gate,
  input  logic [DW-1:0]     adc_in,
  output logic [$clog2(NCH)-1:0] mux_chan,
  output logic [4:0]        gain_code,
  output logic              conv_busy,
  output logic              sample_valid,
  output logic [DW+3:0]     sample_data,
  output logic              overrun
);
  localparam int CW  = $clog2(NCH);
  localparam int LCW = $clog2(LATENCY + 1);

  logic [CW-1:0]  first_ch, last_ch, ptr;
  logic [3:0]     ctrl;
  logic [4:0]     gtab [NCH];
  logic [LCW-1:0] cnt;
  logic           ext_q;

  wire hit_trg  = wr_en && wr_addr == 2'd0;
  wire hit_gain = wr_en && wr_addr == 2'd1;
  wire hit_win  = wr_en && wr_addr == 2'd2;
  wire hit_ctl  = wr_en && wr_addr == 2'd3;

  wire code_ok  = wr_data[15:5] == '0 &&
                  (wr_data[4:3] == 2'b00 || wr_data[4:2] == 3'b100);
  wire gain_we  = hit_gain && code_ok && first_ch == last_ch;

  wire ext_edge = ext_trig && !ext_q;
  wire trig = (ctrl[0] && hit_trg) || (ctrl[1] && pacer_tick) ||
              (ctrl[2] && ext_edge && (!ctrl[3] || ext_gate));
  wire done = conv_busy && cnt == '0;

  wire [CW-1:0] ptr_inc  = (ptr == CW'(NCH - 1)) ? '0 : ptr + 1'b1;
  wire [CW-1:0] ptr_next = (ptr == last_ch) ? first_ch : ptr_inc;

  assign mux_chan  = ptr;
  assign gain_code = gtab[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_ch <= '0;
      last_ch  <= '0;
      ptr      <= '0;
      ctrl     <= '0;
      ext_q    <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      if (hit_ctl) ctrl <= wr_data[3:0];
      if (hit_win) begin
        first_ch <= wr_data[CW-1:0];
        last_ch  <= wr_data[8+CW-1:8];
        ptr      <= wr_data[CW-1:0];
      end else if (done) begin
        ptr <= ptr_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) gtab[i] <= '0;
    end else if (gain_we) begin
      gtab[first_ch] <= wr_data[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_busy    <= 1'b0;
      cnt          <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      overrun      <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (trig && conv_busy) overrun <= 1'b1;
      if (done) begin
        conv_busy    <= 1'b0;
        sample_valid <= 1'b1;
        sample_data  <= {ptr[3:0], adc_in};
      end else if (conv_busy) begin
        cnt <= cnt - 1'b1;
      end else if (trig) begin
        conv_busy <= 1'b1;
        cnt       <= LCW'(LATENCY - 1);
      end
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  // R6
  tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> sample_data[DW+3:DW] == $past(mux_chan[3:0]) && $past(conv_busy));
  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R4
  gain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_we && !hit_win && mux_chan == first_ch) |=> gain_code == $past(wr_data[4:0]));
  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_busy && ctrl == 4'd0 && !hit_ctl) |=> !conv_busy);
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int LAT = 4;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic pacer_tick = 0, ext_trig = 0, ext_gate = 0;
  logic [11:0] adc_in = 0;
  logic [4:0] mux_chan, gain_code;
  logic conv_busy, sample_valid, overrun;
  logic [15:0] sample_data;

  adc_scan_seq #(.NCH(32), .LATENCY(LAT), .DW(12)) u_adc_scan_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pacer_tick, .ext_trig,
    .ext_gate, .adc_in, .mux_chan, .gain_code, .conv_busy, .sample_valid,
    .sample_data, .overrun);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [15:0] expq[$];
  string reqq[$];
  logic [4:0] m_lo = 0, m_hi = 0, m_ptr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sample_valid) begin
      if (expq.size() == 0) chk(0, "R7/R10 unexpected sample", sample_data, 0);
      else begin
        logic [15:0] e;
        string r;
        e = expq.pop_front();
        r = reqq.pop_front();
        chk(sample_data == e, r, sample_data, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_win(input logic [4:0] lo, input logic [4:0] hi);
    wr(2'd2, {3'b0, hi, 3'b0, lo});
    m_lo = lo; m_hi = hi; m_ptr = lo;
  endtask

  task automatic expect_one(input logic [11:0] d, input string req);
    adc_in = d;
    expq.push_back({m_ptr[3:0], d});
    reqq.push_back(req);
    m_ptr = (m_ptr == m_hi) ? m_lo : m_ptr + 5'd1;
  endtask

  task automatic settle();
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic soft_conv(input logic [11:0] d, input string req);
    expect_one(d, req);
    wr(2'd0, 16'h0);
    settle();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mux_chan == 0, "R1 chan", mux_chan, 0);
    chk(gain_code == 0, "R1 gain", gain_code, 0);
    chk(!conv_busy && !overrun && !sample_valid, "R1 flags", {conv_busy, overrun}, 0);
    // R7 strobe ignored while disabled
    wr(2'd0, 0);
    chk(!conv_busy, "R7 disabled strobe", conv_busy, 0);
    settle();

    wr(2'd3, 16'h1);
    // R2 window write
    set_win(5'd3, 5'd3);
    chk(mux_chan == 3, "R2 start channel", mux_chan, 3);
    // R4 gain load
    wr(2'd1, 16'h12);
    chk(gain_code == 5'h12, "R4 gain store", gain_code, 5'h12);
    wr(2'd1, 16'h09);
    chk(gain_code == 5'h12, "R4 invalid code ignored", gain_code, 5'h12);
    set_win(5'd4, 5'd4);
    wr(2'd1, 16'h05);
    set_win(5'd3, 5'd4);
    wr(2'd1, 16'h07);
    chk(gain_code == 5'h12, "R4 wide window ignored", gain_code, 5'h12);
    // R5 gain held during conversion
    expect_one(12'h3A5, "R6 sample ch3");
    wr(2'd0, 0);
    chk(conv_busy && gain_code == 5'h12, "R5 gain during conv", gain_code, 5'h12);
    settle();
    chk(mux_chan == 4 && gain_code == 5'h05, "R5 next channel gain", gain_code, 5'h05);

    // R3 scan inside window
    set_win(5'd5, 5'd7);
    soft_conv(12'h111, "R8 ch5");
    soft_conv(12'h222, "R3 ch6");
    soft_conv(12'h333, "R3 ch7");
    soft_conv(12'h444, "R3 wrap to ch5");
    chk(mux_chan == m_ptr, "R3 pointer", mux_chan, m_ptr);
    // R3 wrap through 31
    set_win(5'd30, 5'd1);
    soft_conv(12'hA30, "R3 ch30");
    soft_conv(12'hA31, "R3 ch31 tag");
    soft_conv(12'hA00, "R3 ch0");
    soft_conv(12'hA01, "R3 ch1");
    chk(mux_chan == 30, "R3 wrap back", mux_chan, 30);

    // R7 pacer only
    wr(2'd3, 16'h2);
    wr(2'd0, 0);
    chk(!conv_busy, "R7 strobe off under pacer", conv_busy, 0);
    expect_one(12'h5A5, "R7 pacer sample");
    pacer_tick = 1; @(negedge clk); pacer_tick = 0;
    settle();
    // R9 external edge
    wr(2'd3, 16'h4);
    expect_one(12'h6B6, "R9 ext sample");
    ext_trig = 1; @(negedge clk);
    repeat (LAT + 3) @(negedge clk);
    ext_trig = 0; @(negedge clk);
    // R9 gated, gate low
    wr(2'd3, 16'hC);
    ext_trig = 1; @(negedge clk); ext_trig = 0;
    chk(!conv_busy, "R9 gate low blocks", conv_busy, 0);
    settle();
    ext_gate = 1;
    expect_one(12'h7C7, "R9 gate high");
    ext_trig = 1; @(negedge clk); ext_trig = 0;
    settle();
    ext_gate = 0;

    // R10 trigger on completion cycle
    wr(2'd3, 16'h1);
    chk(!overrun, "R10 no overrun yet", overrun, 0);
    expect_one(12'h8D8, "R10 single sample");
    wr(2'd0, 0);
    repeat (LAT - 1) @(negedge clk);
    wr(2'd0, 0);
    settle();
    chk(overrun, "R10 overrun set", overrun, 1);
    chk(expq.size() == 0, "R6 all samples seen", expq.size(), 0);
    settle();
    chk(overrun, "R10 overrun sticky", overrun, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule